// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block carries out one bit-level operation per cycle on a byte operand. A bit number picks one position of the byte. An operation code then chooses what to do with that position. It can force the bit high or low, flip it, or write the carry flag (or its complement) into it. It can also examine the bit: copy it into the zero flag, or load it into the carry flag. In the remaining forms the carry flag acts as a one-bit boolean accumulator, combining with the bit (or its complement) through AND, OR or XOR.

The surrounding datapath fetches the byte, presents it here with the current carry and zero flags, and takes back a registered result one cycle later. The result is the byte, a write-back request, and the new flags. The write-back request tells the datapath whether to store the byte at its origin. Only the forms that change the byte raise it. Address generation and the memory read-modify-write sequence belong to the caller.

Top module: `bitop_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid`, `out_wb`, `out_data`, `out_carry` and `out_zero` all at 0.
- R2: Each cycle with `in_valid` high produces exactly one result, with `out_valid` high in the following cycle; a cycle with `in_valid` low gives `out_valid` low in the following cycle.
- R3: Codes 0 (force high), 1 (force low) and 2 (flip) change only bit `idx` of the byte, counting from bit 0 as the least significant. They raise `out_wb` and pass carry and zero through unchanged.
- R4: Code 3 (test) sets `out_zero` to 1 when the selected bit is 0 and to 0 when it is 1. It returns the byte unchanged with `out_wb` low and carry passed through.
- R5: Code 4 loads the selected bit into carry and code 5 loads its complement. Both leave the byte and zero unchanged, with `out_wb` low.
- R6: Code 6 writes the carry into the selected bit and code 7 writes the inverted carry. Other bits stay as they were, `out_wb` is high, and both flags pass through.
- R7: Codes 8/9 give carry AND bit / carry AND NOT bit; 10/11 give OR with bit / OR with NOT bit; 12/13 give XOR with bit / XOR with NOT bit. The result replaces carry. The byte and zero are unchanged, and `out_wb` is low.
- R8: Only the low three bits of the 4-bit `in_idx` select the bit; bit 3 of `in_idx` has no effect.
- R9: Codes 14 and 15 perform no operation. The byte and both flags pass through unchanged, with `out_wb` low.
- R10: In a cycle after `in_valid` was low, `out_wb` is low and `out_data`, `out_carry` and `out_zero` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 4 | Operation code (see R3 to R9) |
| in_data | input | 8 | Operand byte |
| in_idx | input | 4 | Bit number; low three bits used |
| in_carry | input | 1 | Current carry flag |
| in_zero | input | 1 | Current zero flag |
| out_valid | output | 1 | Result present |
| out_data | output | 8 | Resulting byte |
| out_wb | output | 1 | Byte must be written back |
| out_carry | output | 1 | New carry flag |
| out_zero | output | 1 | New zero flag |

## Verification
The functions that share a cycle are the byte update and the flag pass-through. The carry-store forms write a bit using the very carry they must also return unchanged. The accumulator forms rewrite carry while the byte must come back intact. The stimulus runs every code with each pairing of incoming carry and zero, at varied bit positions and byte patterns. Every result is judged on all four outputs together, so a change leaking into the wrong field shows up on the same item.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        BOP_SET     = 4'd0,
        BOP_CLR     = 4'd1,
        BOP_FLIP    = 4'd2,
        BOP_TEST    = 4'd3,
        BOP_LOADC   = 4'd4,
        BOP_LOADCN  = 4'd5,
        BOP_STOREC  = 4'd6,
        BOP_STORECN = 4'd7,
        BOP_CAND    = 4'd8,
        BOP_CANDN   = 4'd9,
        BOP_COR     = 4'd10,
        BOP_CORN    = 4'd11,
        BOP_CXOR    = 4'd12,
        BOP_CXORN   = 4'd13,
        BOP_NOPA    = 4'd14,
        BOP_NOPB    = 4'd15
    } bop_e;

    // What a code does to the byte and flags
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WRITE,
        ACT_ZERO,
        ACT_CARRY
    } bop_act_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } bop_flags_t;

    function automatic bop_act_e bop_class(input bop_e op);
        case (op)
            BOP_SET, BOP_CLR, BOP_FLIP, BOP_STOREC, BOP_STORECN: return ACT_WRITE;
            BOP_TEST:                                           return ACT_ZERO;
            BOP_LOADC, BOP_LOADCN, BOP_CAND, BOP_CANDN,
            BOP_COR, BOP_CORN, BOP_CXOR, BOP_CXORN:             return ACT_CARRY;
            default:                                            return ACT_NONE;
        endcase
    endfunction

    // One-bit boolean accumulator step for the carry forms
    function automatic logic bop_accum(input bop_e op, input logic bitv, input logic c);
        case (op)
            BOP_LOADC:  return bitv;
            BOP_LOADCN: return ~bitv;
            BOP_CAND:   return c & bitv;
            BOP_CANDN:  return c & ~bitv;
            BOP_COR:    return c | bitv;
            BOP_CORN:   return c | ~bitv;
            BOP_CXOR:   return c ^ bitv;
            BOP_CXORN:  return c ^ ~bitv;
            default:    return c;
        endcase
    endfunction

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] mask
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_dec
        assign mask[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/bitop_core.sv
module bitop_core
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bop_e              op,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    input  bop_flags_t        flags_in,
    output logic [DATA_W-1:0] data_out,
    output logic              wb,
    output bop_flags_t        flags_out
);
    logic     sel_bit;
    logic     put_bit;
    bop_act_e act;

    assign sel_bit = |(data & mask);
    assign act     = bop_class(op);

    always_comb begin
        put_bit   = 1'b0;
        data_out  = data;
        wb        = 1'b0;
        flags_out = flags_in;
        case (op)
            BOP_SET:     put_bit = 1'b1;
            BOP_CLR:     put_bit = 1'b0;
            BOP_FLIP:    put_bit = ~sel_bit;
            BOP_STOREC:  put_bit = flags_in.carry;
            BOP_STORECN: put_bit = ~flags_in.carry;
            default:     put_bit = sel_bit;
        endcase
        case (act)
            ACT_WRITE: begin
                data_out = put_bit ? (data | mask) : (data & ~mask);
                wb       = 1'b1;
            end
            ACT_ZERO:  flags_out.zero  = ~sel_bit;
            ACT_CARRY: flags_out.carry = bop_accum(op, sel_bit, flags_in.carry);
            default: ;
        endcase
    end
endmodule

// File: rtl/bitop_outreg.sv
module bitop_outreg
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              wb_in,
    input  bop_flags_t        flags_in,
    output logic              vld_q,
    output logic [DATA_W-1:0] data_q,
    output logic              wb_q,
    output bop_flags_t        flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            data_q  <= '0;
            wb_q    <= 1'b0;
            flags_q <= '0;
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                data_q  <= data_in;
                wb_q    <= wb_in;
                flags_q <= flags_in;
            end else begin
                wb_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IDX_IN_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     in_op,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [IDX_IN_W-1:0] in_idx,
    input  logic                in_carry,
    input  logic                in_zero,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_wb,
    output logic                out_carry,
    output logic                out_zero
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] nxt_data;
    logic              nxt_wb;
    bop_flags_t        cur_flags;
    bop_flags_t        nxt_flags;
    bop_flags_t        reg_flags;
    logic              unused_idx_hi;

    // Bit number is taken modulo the byte width
    assign unused_idx_hi = ^in_idx[IDX_IN_W-1:IDX_W];
    assign cur_flags     = '{carry: in_carry, zero: in_zero};

    bitop_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
        .idx  (in_idx[IDX_W-1:0]),
        .mask (mask)
    );

    bitop_core #(.DATA_W(DATA_W)) u_core (
        .op        (bop_e'(in_op)),
        .data      (in_data),
        .mask      (mask),
        .flags_in  (cur_flags),
        .data_out  (nxt_data),
        .wb        (nxt_wb),
        .flags_out (nxt_flags)
    );

    bitop_outreg #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .vld_in   (in_valid),
        .data_in  (nxt_data),
        .wb_in    (nxt_wb),
        .flags_in (nxt_flags),
        .vld_q    (out_valid),
        .data_q   (out_data),
        .wb_q     (out_wb),
        .flags_q  (reg_flags)
    );

    assign out_carry = reg_flags.carry;
    assign out_zero  = reg_flags.zero;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
    import bitop_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IDX_IN_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [OP_W-1:0]     in_op,
    input logic [DATA_W-1:0]   in_data,
    input logic [IDX_IN_W-1:0] in_idx,
    input logic                in_carry,
    input logic                in_zero,
    input logic                out_valid,
    input logic [DATA_W-1:0]   out_data,
    input logic                out_wb,
    input logic                out_carry,
    input logic                out_zero
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] chk_mask;
    logic              is_rmw, is_test, is_store, is_acc, is_nop;

    assign chk_mask = DATA_W'(1) << in_idx[IDX_W-1:0];
    assign is_rmw   = in_valid && (in_op == BOP_SET || in_op == BOP_CLR || in_op == BOP_FLIP);
    assign is_test  = in_valid && (in_op == BOP_TEST);
    assign is_store = in_valid && (in_op == BOP_STOREC || in_op == BOP_STORECN);
    assign is_acc   = in_valid && (in_op == BOP_LOADC || in_op == BOP_LOADCN
                                   || (in_op >= BOP_CAND && in_op <= BOP_CXORN));
    assign is_nop   = in_valid && (in_op == BOP_NOPA || in_op == BOP_NOPB);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R2
    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_wb);  // R10
    AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        is_rmw |=> out_wb && (((out_data ^ $past(in_data)) & ~$past(chk_mask)) == '0)
                   && out_carry == $past(in_carry) && out_zero == $past(in_zero));  // R3
    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (rst)
        is_test |=> !out_wb && out_data == $past(in_data) && out_carry == $past(in_carry)
                    && out_zero == ~|($past(in_data) & $past(chk_mask)));  // R4
    AST_STORE_CARRY: assert property (@(posedge clk) disable iff (rst)
        is_store |=> out_wb
                     && ((|(out_data & $past(chk_mask))) == ($past(in_carry) ^ ($past(in_op) == BOP_STORECN)))
                     && out_carry == $past(in_carry) && out_zero == $past(in_zero));  // R6
    AST_ACC_NO_WB: assert property (@(posedge clk) disable iff (rst)
        is_acc |=> !out_wb && out_data == $past(in_data) && out_zero == $past(in_zero));  // R7
    AST_NOP_PASS: assert property (@(posedge clk) disable iff (rst)
        is_nop |=> !out_wb && out_data == $past(in_data) && out_carry == $past(in_carry)
                   && out_zero == $past(in_zero));  // R9
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .IDX_IN_W(IDX_IN_W)) u_chk (.*);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

    typedef struct {
        logic [7:0] data;
        logic       wb;
        logic       c;
        logic       z;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_op = '0;
    logic [7:0] in_data = '0;
    logic [3:0] in_idx = '0;
    logic       in_carry = 1'b0;
    logic       in_zero = 1'b0;
    logic       out_valid, out_wb, out_carry, out_zero;
    logic [7:0] out_data;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   n_push  = 0;
    int   n_pop   = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #2 clk = ~clk;

    bitop_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .in_idx(in_idx), .in_carry(in_carry), .in_zero(in_zero),
        .out_valid(out_valid), .out_data(out_data), .out_wb(out_wb),
        .out_carry(out_carry), .out_zero(out_zero)
    );

    task automatic check(input bit ok, input string req, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic exp_t model(input logic [3:0] op, input logic [7:0] d,
                                   input logic [3:0] idx, input logic c, input logic z);
        exp_t       e;
        logic [7:0] m;
        logic       b;
        m = 8'd1 << idx[2:0];
        b = d[idx[2:0]];
        e.data = d; e.wb = 1'b0; e.c = c; e.z = z;
        case (op)
            4'd0:  begin e.data = d | m;  e.wb = 1'b1; e.tag = "R3"; end
            4'd1:  begin e.data = d & ~m; e.wb = 1'b1; e.tag = "R3"; end
            4'd2:  begin e.data = d ^ m;  e.wb = 1'b1; e.tag = "R3"; end
            4'd3:  begin e.z = ~b; e.tag = "R4"; end
            4'd4:  begin e.c = b;  e.tag = "R5"; end
            4'd5:  begin e.c = ~b; e.tag = "R5"; end
            4'd6:  begin e.data = c ? (d | m) : (d & ~m);  e.wb = 1'b1; e.tag = "R6"; end
            4'd7:  begin e.data = !c ? (d | m) : (d & ~m); e.wb = 1'b1; e.tag = "R6"; end
            4'd8:  begin e.c = c & b;  e.tag = "R7"; end
            4'd9:  begin e.c = c & ~b; e.tag = "R7"; end
            4'd10: begin e.c = c | b;  e.tag = "R7"; end
            4'd11: begin e.c = c | ~b; e.tag = "R7"; end
            4'd12: begin e.c = c ^ b;  e.tag = "R7"; end
            4'd13: begin e.c = c ^ ~b; e.tag = "R7"; end
            default: e.tag = "R9";
        endcase
        if (idx[3]) e.tag = {e.tag, "/R8"};
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] d,
                         input logic [3:0] idx, input logic c, input logic z);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_data = d; in_idx = idx;
        in_carry = c; in_zero = z;
        sb_q.push_back(model(op, d, idx, c, z));
        n_push++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_op = 4'd2; in_data = 8'h5A; in_idx = 4'd1; in_carry = 1'b1; in_zero = 1'b1;
    endtask

    // Monitor: pop and compare every produced result
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "result with no pending request");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                n_pop++;
                last_exp = e;
                check(out_data == e.data && out_wb == e.wb && out_carry == e.c && out_zero == e.z,
                      e.tag,
                      $sformatf("got data=%h wb=%0d c=%0d z=%0d exp data=%h wb=%0d c=%0d z=%0d",
                                out_data, out_wb, out_carry, out_zero, e.data, e.wb, e.c, e.z));
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h00; pats[2] = 8'hFF; pats[3] = 8'h3C;

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_wb == 1'b0 && out_data == 8'h00
              && out_carry == 1'b0 && out_zero == 1'b0, "R1",
              $sformatf("reset state got v=%0d wb=%0d d=%h c=%0d z=%0d exp all 0",
                        out_valid, out_wb, out_data, out_carry, out_zero));
        @(negedge clk);
        rst = 1'b0;

        // Every code, four patterns, all flag pairings, mixed bit numbers
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 4; k++) begin
                drive(4'(op), pats[k], 4'((op * 3 + k * 5) % 16), k[0], k[1]);
            end
        end

        // Boundary positions and high index bit (R8)
        drive(4'd0, 8'h00, 4'd7,  1'b0, 1'b0);   // R3 top bit
        drive(4'd1, 8'hFF, 4'd0,  1'b1, 1'b1);   // R3 bottom bit
        drive(4'd3, 8'h7F, 4'd15, 1'b1, 1'b0);   // R8 index 15 -> bit 7
        drive(4'd6, 8'hF0, 4'd8,  1'b1, 1'b0);   // R8 index 8 -> bit 0
        drive(4'd4, 8'h08, 4'd11, 1'b0, 1'b1);   // R8 index 11 -> bit 3

        // Idle gap: outputs must hold, no write-back (R10)
        idle();
        @(negedge clk);
        check(out_valid == 1'b0 && out_wb == 1'b0, "R10",
              $sformatf("idle got v=%0d wb=%0d exp 0 0", out_valid, out_wb));
        check(out_data == last_exp.data && out_carry == last_exp.c && out_zero == last_exp.z, "R10",
              $sformatf("hold got d=%h c=%0d z=%0d exp d=%h c=%0d z=%0d",
                        out_data, out_carry, out_zero, last_exp.data, last_exp.c, last_exp.z));

        // Back-to-back after a gap, then drain
        drive(4'd2, 8'h81, 4'd7, 1'b0, 1'b1);
        drive(4'd13, 8'h81, 4'd0, 1'b1, 1'b0);
        idle();
        repeat (2) @(negedge clk);
        check(n_push == n_pop && sb_q.size() == 0, "R2",
              $sformatf("results got %0d exp %0d", n_pop, n_push));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule